// File: doc/BRIEF.md
# Selectable Baud-Rate Clock Generator

This block derives the sampling clock for a serial receiver that takes sixteen samples per bit. A three-bit rate select picks one of eight teleprinter and low-speed data rates. A reloading down-counter divides the master clock by a half-period count taken from a table. Each time the count expires, a toggle flop flips, so the high and low phases of the output always last the same number of master cycles. This holds even for rates such as 45.5 baud, where a single divider could not give an exact square wave.

The table is computed when the design is elaborated, from the master clock frequency parameter. A change of rate select never cuts a phase short: the new count is loaded only when the phase in progress ends. A further divide by sixteen of the output's rising edges gives a one-cycle baud tick, which a transmitter can use as its bit strobe.

Top module: `baudClockGen`

## Requirements
- R1: Each phase of `clk16x` lasts D master cycles, where D = floor((CLK_HZ*10 + 16*T) / (32*T)), with a minimum of 1, and T is the selected rate in tenths of a baud. The output period is therefore 2*D cycles, which is sixteen times the selected rate.
- R2: The high phase and the low phase of `clk16x` are equal in length (50 % duty).
- R3: `rateSel` codes 0 to 7 select T = 455, 500, 569, 750, 1000, 1100, 1500 and 3000 tenths of a baud (45.5 to 300 baud, in that order).
- R4: A change of `rateSel` has no effect on the phase in progress. The value present at the edge where that phase ends sets the length of the next phase. A change that is undone before the phase ends has no effect at all.
- R5: `baudTick` is high for exactly one master cycle. It rises together with every 16th rising edge of `clk16x`, counted from reset, and is low at every other time.
- R6: While `rst` is high, both `clk16x` and `baudTick` are low, including when reset arrives during a high phase. After `rst` is released, the first rising edge of `clk16x` comes D cycles later, where D is the count for the rate selected during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| rateSel | input | 3 | Baud-rate select code |
| clk16x | output | 1 | Square-wave clock at 16x the selected rate |
| baudTick | output | 1 | One-cycle pulse once per bit period |

## Verification
The bench goes after the phase where the rate select changes. A design that reloads the counter as soon as the select moves would produce a runt or stretched phase, instead of finishing the old one and then switching. It also drives a select that is changed and then restored within one phase, which must leave the output untouched. The tick is checked at every sampled cycle: a tick that is off by one edge, lasts two cycles or starts counting from the wrong edge shows up as a misplaced or missing pulse. Reset is applied in the middle of a high phase, and the time to the first rising edge after reset is measured. A counter that is loaded one short or one long is caught there.

// File: rtl/baudGenPkg.sv
package baudGenPkg;

  localparam int TICK_DIV = 16;

  typedef struct packed {
    logic reload;
    logic toggle;
  } divStrobe_t;

  // Selectable rates in tenths of a baud.
  function automatic int rateTenths(input int idx);
    case (idx)
      0:       return 455;
      1:       return 500;
      2:       return 569;
      3:       return 750;
      4:       return 1000;
      5:       return 1100;
      6:       return 1500;
      default: return 3000;
    endcase
  endfunction

  // Master cycles per half period of the 16x clock, rounded to nearest.
  function automatic int halfDivisor(input longint clkHz, input int idx);
    longint den;
    longint quo;
    den = 64'(32 * rateTenths(idx));
    quo = (clkHz * 10 + den / 2) / den;
    if (quo < 1) quo = 1;
    return int'(quo);
  endfunction

endpackage

// File: rtl/baudRateTable.sv
module baudRateTable #(
  parameter longint CLK_HZ    = 1_843_200,
  parameter int     NUM_RATES = 8,
  parameter int     SEL_W     = 3,
  parameter int     CNT_W     = 11
) (
  input  logic [SEL_W-1:0] rateSel,
  output logic [CNT_W-1:0] halfCount
);
  import baudGenPkg::*;

  logic [CNT_W-1:0] divTable [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_entry
    assign divTable[g] = CNT_W'(halfDivisor(CLK_HZ, g));
  end

  assign halfCount = divTable[rateSel];

endmodule

// File: rtl/baudDivPath.sv
module baudDivPath #(
  parameter int CNT_W   = 11,
  parameter int MAX_DIV = 1266
) (
  input  logic                   clk,
  input  logic                   rst,
  input  baudGenPkg::divStrobe_t strobe,
  input  logic [CNT_W-1:0]       loadVal,
  output logic                   zero,
  output logic                   clk16x
);

  logic [CNT_W-1:0] cnt;
  logic             clkReg;

  always_ff @(posedge clk) begin
    if (strobe.reload) cnt <= loadVal - 1'b1;
    else               cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                clkReg <= 1'b0;
    else if (strobe.toggle) clkReg <= ~clkReg;
  end

  assign zero   = (cnt == '0);
  assign clk16x = clkReg;

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < MAX_DIV);

  p_reload_next_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.reload |=> (cnt == $past(loadVal) - 1'b1));

  p_hold_phase_r2: assert property (@(posedge clk) disable iff (rst)
    !strobe.toggle |=> $stable(clkReg));

  p_reset_low_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !clkReg);

endmodule

// File: rtl/baudCtrl.sv
module baudCtrl #(
  parameter int TICK_DIV = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   zero,
  input  logic                   clk16x,
  output baudGenPkg::divStrobe_t strobe,
  output logic                   baudTick
);
  localparam int EDGE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(TICK_DIV - 1);

  logic [EDGE_W-1:0] edgeCnt;
  logic              rising;
  logic              tickReg;

  always_comb begin
    strobe.reload = rst || zero;
    strobe.toggle = zero && !rst;
  end

  assign rising = strobe.toggle && !clk16x;

  always_ff @(posedge clk) begin
    if (rst) begin
      edgeCnt <= '0;
      tickReg <= 1'b0;
    end else begin
      tickReg <= rising && (edgeCnt == LAST_EDGE);
      if (rising) edgeCnt <= (edgeCnt == LAST_EDGE) ? '0 : edgeCnt + 1'b1;
    end
  end

  assign baudTick = tickReg;

  p_tick_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
    tickReg |-> (clk16x && !$past(clk16x)));

  p_tick_single_r5: assert property (@(posedge clk) disable iff (rst)
    tickReg |=> !tickReg);

  p_tick_reset_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !tickReg);

endmodule

// File: rtl/baudClockGen.sv
module baudClockGen #(
  parameter longint CLK_HZ    = 1_843_200,
  parameter int     NUM_RATES = 8,
  localparam int    SEL_W     = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rateSel,
  output logic             clk16x,
  output logic             baudTick
);
  import baudGenPkg::*;

  localparam int MAX_DIV = halfDivisor(CLK_HZ, 0);
  localparam int CNT_W   = $clog2(MAX_DIV + 1);

  divStrobe_t       strobe;
  logic [CNT_W-1:0] halfCount;
  logic             zero;

  baudRateTable #(
    .CLK_HZ(CLK_HZ), .NUM_RATES(NUM_RATES), .SEL_W(SEL_W), .CNT_W(CNT_W)
  ) uTable (
    .rateSel(rateSel),
    .halfCount(halfCount)
  );

  baudDivPath #(.CNT_W(CNT_W), .MAX_DIV(MAX_DIV)) uPath (
    .clk(clk), .rst(rst), .strobe(strobe), .loadVal(halfCount),
    .zero(zero), .clk16x(clk16x)
  );

  baudCtrl #(.TICK_DIV(TICK_DIV)) uCtrl (
    .clk(clk), .rst(rst), .zero(zero), .clk16x(clk16x),
    .strobe(strobe), .baudTick(baudTick)
  );

endmodule

// File: tb/tb_baudClockGen.sv
`timescale 1ns/1ps
module tb_baudClockGen;
  localparam longint CLK_HZ = 96000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rateSel = 3'd0;
  logic       clk16x;
  logic       baudTick;
  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  baudClockGen #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst(rst), .rateSel(rateSel), .clk16x(clk16x), .baudTick(baudTick)
  );

  // R3 rate table and R1 rounding rule, written from the requirements.
  function automatic int expDiv(input int sel);
    int t;
    case (sel)
      0: t = 455;   1: t = 500;   2: t = 569;   3: t = 750;
      4: t = 1000;  5: t = 1100;  6: t = 1500;  default: t = 3000;
    endcase
    return int'((CLK_HZ * 10 + 16 * t) / (32 * t));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic applyReset(input int sel);
    @(negedge clk);
    rateSel = 3'(sel);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Cycles from now until the sample where clk16x is first seen high.
  task automatic waitRise(output int n);
    while (clk16x) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!clk16x && n < 2000);
  endtask

  // Current sample is at level lvl; counts the samples of this run.
  task automatic runLen(input logic lvl, output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (clk16x == lvl && n < 2000) n++;
      else break;
    end
  endtask

  task automatic testReset();
    int n;
    @(negedge clk);
    rateSel = 3'd2;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6", "clk16x in reset", int'(clk16x), 0);
    chk("R6", "tick in reset", int'(baudTick), 0);
    rst = 1'b0;
    waitRise(n);
    chk("R6", "first rise delay", n, expDiv(2));
    // reset arriving during a high phase
    rst = 1'b1;
    @(negedge clk);
    chk("R6", "clk16x after mid-high reset", int'(clk16x), 0);
    rst = 1'b0;
  endtask

  task automatic testRates();
    int w, h, l;
    for (int s = 0; s < 8; s++) begin
      applyReset(s);
      waitRise(w);
      runLen(1'b1, h);
      runLen(1'b0, l);
      chk("R3", $sformatf("first rise sel %0d", s), w, expDiv(s));
      chk("R1", $sformatf("high phase sel %0d", s), h, expDiv(s));
      chk("R2", $sformatf("low phase sel %0d", s), l, expDiv(s));
    end
  endtask

  task automatic testSwitch();
    int w, h, l, h2;
    applyReset(7);
    waitRise(w);
    h = 1;
    repeat (3) begin
      @(negedge clk);
      if (clk16x) h++;
    end
    rateSel = 3'd0;
    forever begin
      @(negedge clk);
      if (clk16x && h < 2000) h++;
      else break;
    end
    runLen(1'b0, l);
    runLen(1'b1, h2);
    chk("R4", "phase in progress keeps old count", h, expDiv(7));
    chk("R4", "next low uses new count", l, expDiv(0));
    chk("R4", "following high uses new count", h2, expDiv(0));
  endtask

  task automatic testGlitch();
    int w, h, l, h2;
    applyReset(7);
    waitRise(w);
    runLen(1'b1, h);
    l = 1;
    @(negedge clk); l++;
    rateSel = 3'd0;
    @(negedge clk); l++;
    rateSel = 3'd7;
    forever begin
      @(negedge clk);
      if (!clk16x && l < 2000) l++;
      else break;
    end
    runLen(1'b1, h2);
    chk("R4", "restored select low phase", l, expDiv(7));
    chk("R4", "restored select high phase", h2, expDiv(7));
  endtask

  task automatic testTick();
    int rises = 0, ticks = 0, bad = 0, missed = 0;
    logic prev;
    logic isRise;
    applyReset(7);
    prev = clk16x;
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk);
      isRise = clk16x && !prev;
      if (isRise) rises++;
      if (baudTick) begin
        ticks++;
        if (!isRise || (rises % 16) != 0) bad++;
      end else if (isRise && (rises % 16) == 0) begin
        missed++;
      end
      prev = clk16x;
    end
    chk("R5", "tick count", ticks, rises / 16);
    chk("R5", "misplaced ticks", bad, 0);
    chk("R5", "missing ticks", missed, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testRates();
    testSwitch();
    testGlitch();
    testTick();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule